// File: doc/BRIEF.md
# Thread-Block Barrier Controller with Boolean Reduction

This block coordinates the threads of one thread block at a small set of numbered barriers. A thread arrives with a single request beat that carries its thread number, a barrier number, the arrival kind, an optional participant count, a reduction predicate and a reduction operator. There are three arrival kinds. A blocking sync holds the thread until the barrier completes. A non-blocking arrive only counts toward the barrier. A blocking reduce also contributes a predicate to a reduction. A barrier completes on the arrival that brings its arrival count up to its participant count. Completion clears the barrier's state in that same cycle, so the barrier number can be used again at once.

Each thread has a stall flag that the warp scheduler uses to hold that thread's warp. Blocking arrivals also raise a block-level fence-pending flag for the thread. An external per-thread fence-complete mask clears that flag. A thread is stalled while it waits at a barrier or while its fence is pending. When a barrier with at least one reducer completes, a one-cycle result beat gives the reduction value and a mask of the reducing threads that should write it back.

The request port is valid/ready. A beat transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` depends only on the thread number presented, and it is low while that thread is stalled. The upstream must hold a beat steady until it transfers. The result beat has no ready signal. It is a single-cycle pulse that the consumer must take when it appears. Errors are reported as one-cycle pulses on plain status pins.

Top module: `block_barrier`

## Requirements
- R1: A transferred beat whose barrier number is NBAR or higher pulses `err_req` in the next cycle. It counts toward no barrier and stalls no thread.
- R2: A sync (kind code 0) with `req_has_cnt` low uses NTHREADS as its participant count.
- R3: An arrive (kind code 1) never stalls its thread. An arrive with `req_has_cnt` low, a count of 0, or kind code 3 pulses `err_req` and is not counted.
- R4: A barrier completes on the beat that makes its arrival count equal its latched participant count. Threads waiting at it lose their stall in the cycle after that beat transfers, unless their fence is pending.
- R5: A transferred sync or reduce (kind code 2) sets its thread's fence flag in the next cycle. The thread stays stalled until both the barrier has completed and the fence flag is cleared by a high bit of `fence_clr`. While the barrier is incomplete, clearing the fence does not release the thread.
- R6: When a barrier with reducers completes, `red_valid` pulses in the next cycle. `red_mask` then holds the reducing threads and `red_bar` holds the barrier number. The operator is latched from the first reducer, with codes 0 = AND, 1 = OR, 2 = count of true predicates, 3 = OR. AND and OR give their result in bit 0 of `red_value`.
- R7: The first arrival on an idle barrier latches the participant count. A later arrival with a different count pulses `err_mismatch` in the next cycle and is counted against the latched value.
- R8: After reset, no thread is stalled and `red_valid`, `err_req` and `err_mismatch` are low.
- R9: A barrier that completed can be used again on the very next beat with a fresh count and fresh reduction state.
- R10: `req_ready` is low exactly when the thread named on `req_tid` is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Arrival beat valid |
| req_ready | output | 1 | Arrival beat accepted; low while the named thread is stalled |
| req_tid | input | TID_W | Arriving thread number |
| req_idx | input | IDX_W | Barrier number |
| req_kind | input | 2 | 0 sync, 1 arrive, 2 reduce, 3 reserved |
| req_has_cnt | input | 1 | Participant count supplied |
| req_cnt | input | CNT_W | Participant count |
| req_pred | input | 1 | Reduction predicate |
| req_op | input | 2 | Reduction operator code |
| fence_clr | input | NTHREADS | Per-thread fence-complete mask |
| stall | output | NTHREADS | Per-thread hold flag for the scheduler |
| red_valid | output | 1 | Reduction result pulse |
| red_bar | output | IDX_W | Barrier that produced the result |
| red_value | output | CNT_W | Reduction result |
| red_mask | output | NTHREADS | Threads that should write the result back |
| err_req | output | 1 | Malformed or out-of-range arrival pulse |
| err_mismatch | output | 1 | Participant count disagreement pulse |

## Verification
The hardest case to reach from the ports is a thread whose fence has already been cleared while its barrier is still incomplete. The stall must then come from the barrier wait alone, and it must drop in exactly the cycle after the completing arrival. The stimulus gets there by parking a sync on a barrier, clearing that thread's fence, and finishing the barrier with non-blocking arrives from other threads. A second hard case is a barrier that completes and is reused at once with a different operator. Back-to-back reduce groups on the same barrier number cover it, and each group's result is compared against a value computed from its own predicates.

// File: rtl/block_barrier_pkg.sv
package block_barrier_pkg;
  typedef enum logic [1:0] {
    K_SYNC   = 2'd0,
    K_ARRIVE = 2'd1,
    K_REDUCE = 2'd2,
    K_RSVD   = 2'd3
  } bar_kind_e;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_POPC = 2'd2,
    OP_ALT  = 2'd3
  } red_op_e;
endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import block_barrier_pkg::*;
#(
  parameter int NTHREADS = 8,
  parameter int TID_W    = 3,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [TID_W-1:0]    tid,
  input  bar_kind_e           kind,
  input  logic [CNT_W-1:0]    eff_cnt,
  input  logic                pred,
  input  red_op_e             op,
  output logic                done,
  output logic                mismatch,
  output logic [NTHREADS-1:0] release_mask,
  output logic                red_any,
  output logic [NTHREADS-1:0] red_mask,
  output logic [CNT_W-1:0]    red_val
);
  logic                active_q, have_op_q, and_q, or_q;
  logic [CNT_W-1:0]    tgt_q, n_q, pop_q;
  red_op_e             op_q;
  logic [NTHREADS-1:0] wmask_q, rmask_q;

  logic                is_red, blk, and_n, or_n;
  logic [CNT_W-1:0]    tgt, n_n, pop_n;
  logic [NTHREADS-1:0] tbit, wmask_n, rmask_n;
  red_op_e             op_n;

  always_comb begin
    is_red   = (kind == K_REDUCE);
    blk      = (kind == K_SYNC) || is_red;
    tbit     = NTHREADS'(1) << tid;
    tgt      = active_q ? tgt_q : eff_cnt;
    n_n      = n_q + CNT_W'(1);
    done     = hit && (n_n == tgt);
    mismatch = hit && active_q && (eff_cnt != tgt_q);
    and_n    = and_q & (pred | ~is_red);
    or_n     = or_q | (pred & is_red);
    pop_n    = pop_q + CNT_W'(pred & is_red);
    op_n     = have_op_q ? op_q : op;
    rmask_n  = rmask_q | (is_red ? tbit : '0);
    wmask_n  = wmask_q | (blk ? tbit : '0);
    release_mask = done ? wmask_q : '0;
    red_any  = done && (rmask_n != '0);
    red_mask = rmask_n;
    case (op_n)
      OP_AND:  red_val = CNT_W'(and_n);
      OP_POPC: red_val = pop_n;
      default: red_val = CNT_W'(or_n);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      active_q  <= 1'b0;
      have_op_q <= 1'b0;
      and_q     <= 1'b1;
      or_q      <= 1'b0;
      tgt_q     <= '0;
      n_q       <= '0;
      pop_q     <= '0;
      op_q      <= OP_AND;
      wmask_q   <= '0;
      rmask_q   <= '0;
    end else if (hit) begin
      active_q  <= 1'b1;
      have_op_q <= have_op_q | is_red;
      and_q     <= and_n;
      or_q      <= or_n;
      tgt_q     <= tgt;
      n_q       <= n_n;
      pop_q     <= pop_n;
      op_q      <= op_n;
      wmask_q   <= wmask_n;
      rmask_q   <= rmask_n;
    end
  end
endmodule

// File: rtl/thread_flags.sv
module thread_flags #(
  parameter int NTHREADS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHREADS-1:0] set_wait,
  input  logic [NTHREADS-1:0] rel_wait,
  input  logic [NTHREADS-1:0] set_fence,
  input  logic [NTHREADS-1:0] clr_fence,
  output logic [NTHREADS-1:0] stall
);
  logic [NTHREADS-1:0] wait_q, fence_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q  <= '0;
      fence_q <= '0;
    end else begin
      wait_q  <= (wait_q & ~rel_wait) | set_wait;
      fence_q <= (fence_q & ~clr_fence) | set_fence;
    end
  end

  assign stall = wait_q | fence_q;
endmodule

// File: rtl/block_barrier.sv
module block_barrier
  import block_barrier_pkg::*;
#(
  parameter int NTHREADS = 8,
  parameter int NBAR     = 4,
  parameter int IDX_W    = 3,
  localparam int TID_W   = $clog2(NTHREADS),
  localparam int CNT_W   = $clog2(NTHREADS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TID_W-1:0]    req_tid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic [1:0]          req_kind,
  input  logic                req_has_cnt,
  input  logic [CNT_W-1:0]    req_cnt,
  input  logic                req_pred,
  input  logic [1:0]          req_op,
  input  logic [NTHREADS-1:0] fence_clr,
  output logic [NTHREADS-1:0] stall,
  output logic                red_valid,
  output logic [IDX_W-1:0]    red_bar,
  output logic [CNT_W-1:0]    red_value,
  output logic [NTHREADS-1:0] red_mask,
  output logic                err_req,
  output logic                err_mismatch
);
  localparam logic [IDX_W:0]   NBAR_L = NBAR[IDX_W:0];
  localparam logic [CNT_W-1:0] FULL_L = NTHREADS[CNT_W-1:0];

  bar_kind_e           kind;
  logic                acc, good, blk, idx_ok, kind_ok, cnt_ok;
  logic [CNT_W-1:0]    eff_cnt;
  logic [NTHREADS-1:0] tbit;

  logic [NBAR-1:0]     hit_v, done_v, mm_v, rany_v;
  logic [NTHREADS-1:0] rel_v   [NBAR];
  logic [NTHREADS-1:0] rmask_v [NBAR];
  logic [CNT_W-1:0]    rval_v  [NBAR];

  logic                any_done, any_mm, any_red;
  logic [NTHREADS-1:0] rel_all, rmask_sel;
  logic [CNT_W-1:0]    rval_sel;

  assign req_ready = ~stall[req_tid];

  always_comb begin
    kind    = bar_kind_e'(req_kind);
    acc     = req_valid && req_ready;
    idx_ok  = {1'b0, req_idx} < NBAR_L;
    kind_ok = (kind != K_RSVD);
    cnt_ok  = (kind != K_ARRIVE || req_has_cnt) &&
              (!req_has_cnt || (req_cnt != '0 && req_cnt <= FULL_L));
    good    = acc && idx_ok && kind_ok && cnt_ok;
    blk     = (kind == K_SYNC) || (kind == K_REDUCE);
    eff_cnt = req_has_cnt ? req_cnt : FULL_L;
    tbit    = NTHREADS'(1) << req_tid;
  end

  for (genvar b = 0; b < NBAR; b++) begin : g_slot
    assign hit_v[b] = good && (req_idx == IDX_W'(b));
    bar_slot #(
      .NTHREADS(NTHREADS), .TID_W(TID_W), .CNT_W(CNT_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit_v[b]),
      .tid         (req_tid),
      .kind        (kind),
      .eff_cnt     (eff_cnt),
      .pred        (req_pred),
      .op          (red_op_e'(req_op)),
      .done        (done_v[b]),
      .mismatch    (mm_v[b]),
      .release_mask(rel_v[b]),
      .red_any     (rany_v[b]),
      .red_mask    (rmask_v[b]),
      .red_val     (rval_v[b])
    );
  end

  always_comb begin
    rel_all   = '0;
    rmask_sel = '0;
    rval_sel  = '0;
    for (int b = 0; b < NBAR; b++) begin
      rel_all |= rel_v[b];
      if (hit_v[b]) begin
        rmask_sel = rmask_v[b];
        rval_sel  = rval_v[b];
      end
    end
    any_done = |done_v;
    any_mm   = |mm_v;
    any_red  = |rany_v;
  end

  thread_flags #(.NTHREADS(NTHREADS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_wait ((good && blk && !any_done) ? tbit : '0),
    .rel_wait (rel_all),
    .set_fence((good && blk) ? tbit : '0),
    .clr_fence(fence_clr),
    .stall    (stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_valid    <= 1'b0;
      red_bar      <= '0;
      red_value    <= '0;
      red_mask     <= '0;
      err_req      <= 1'b0;
      err_mismatch <= 1'b0;
    end else begin
      red_valid    <= any_red;
      red_bar      <= any_red ? req_idx : red_bar;
      red_value    <= any_red ? rval_sel : red_value;
      red_mask     <= any_red ? rmask_sel : red_mask;
      err_req      <= acc && !good;
      err_mismatch <= any_mm;
    end
  end
endmodule

// File: rtl/block_barrier_chk.sv
module block_barrier_chk #(
  parameter int NTHREADS = 8,
  parameter int NBAR     = 4,
  parameter int IDX_W    = 3,
  localparam int TID_W   = $clog2(NTHREADS),
  localparam int CNT_W   = $clog2(NTHREADS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [TID_W-1:0]    req_tid,
  input logic [IDX_W-1:0]    req_idx,
  input logic [1:0]          req_kind,
  input logic                req_has_cnt,
  input logic [CNT_W-1:0]    req_cnt,
  input logic [NTHREADS-1:0] stall,
  input logic                red_valid,
  input logic [NTHREADS-1:0] red_mask,
  input logic                err_req,
  input logic                err_mismatch
);
  localparam logic [IDX_W:0] NBAR_L = NBAR[IDX_W:0];
  logic xfer;
  assign xfer = req_valid && req_ready;

  p_bad_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ({1'b0, req_idx} >= NBAR_L)) |=> (err_req && !stall[$past(req_tid)]));

  p_arrive_nostall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && req_kind == 2'd1) |=> !stall[$past(req_tid)]);

  p_block_sets_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ({1'b0, req_idx} < NBAR_L) && (req_kind == 2'd0 || req_kind == 2'd2) &&
     (!req_has_cnt || req_cnt != '0)) |=> stall[$past(req_tid)]);

  p_result_has_reducers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    red_valid |-> (red_mask != '0));

  p_mismatch_needs_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_mismatch |-> $past(xfer));

  p_ready_tracks_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !stall[req_tid]);
endmodule

bind block_barrier block_barrier_chk #(
  .NTHREADS(NTHREADS), .NBAR(NBAR), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_tid(req_tid), .req_idx(req_idx), .req_kind(req_kind),
  .req_has_cnt(req_has_cnt), .req_cnt(req_cnt), .stall(stall),
  .red_valid(red_valid), .red_mask(red_mask), .err_req(err_req),
  .err_mismatch(err_mismatch)
);

// File: tb/block_barrier_bench.sv
module block_barrier_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_tid = '0, req_idx = '0;
  logic [1:0] req_kind = '0, req_op = '0;
  logic req_has_cnt = 1'b0, req_pred = 1'b0;
  logic [3:0] req_cnt = '0;
  logic [N-1:0] fence_clr = '0, stall, red_mask;
  logic red_valid, err_req, err_mismatch;
  logic [2:0] red_bar;
  logic [3:0] red_value;

  int total = 0, bad = 0;
  logic s_rv, s_er, s_em;
  logic [3:0] s_val;
  logic [N-1:0] s_mask;
  logic [2:0] s_bar;

  always #10 clk = ~clk;

  block_barrier u_block_barrier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tid(req_tid), .req_idx(req_idx), .req_kind(req_kind),
    .req_has_cnt(req_has_cnt), .req_cnt(req_cnt), .req_pred(req_pred),
    .req_op(req_op), .fence_clr(fence_clr), .stall(stall),
    .red_valid(red_valid), .red_bar(red_bar), .red_value(red_value),
    .red_mask(red_mask), .err_req(err_req), .err_mismatch(err_mismatch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int tid, input int idx, input int kind, input bit hc,
                      input int cnt, input bit pred, input int op);
    @(negedge clk);
    req_tid = 3'(tid); req_idx = 3'(idx); req_kind = 2'(kind);
    req_has_cnt = hc; req_cnt = 4'(cnt); req_pred = pred; req_op = 2'(op);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    s_rv = red_valid; s_er = err_req; s_em = err_mismatch;
    s_val = red_value; s_mask = red_mask; s_bar = red_bar;
  endtask

  task automatic clear_fence(input logic [N-1:0] m);
    @(negedge clk);
    fence_clr = m;
    @(negedge clk);
    fence_clr = '0;
  endtask

  task automatic t_reset;
    chk("R8 stall", stall, 0);
    chk("R8 red_valid", red_valid, 0);
    chk("R8 err_req", err_req, 0);
    chk("R8 err_mismatch", err_mismatch, 0);
  endtask

  task automatic t_sync_all;
    for (int t = 0; t < N; t++) begin
      send(t, 0, 0, 1'b0, 0, 1'b0, 0);
      if (t == 2) begin
        clear_fence(8'h07);
        chk("R5 fence cleared but barrier open", stall, 8'h07);
      end
    end
    chk("R2 R4 default count completes", stall, 8'hF8);
    chk("R6 no reducers no result", s_rv, 0);
    clear_fence(8'hFF);
    chk("R5 all released", stall, 0);
  endtask

  task automatic t_arrive;
    send(0, 1, 0, 1'b1, 3, 1'b0, 0);
    clear_fence(8'h01);
    chk("R4 waiting without fence", stall[0], 1);
    send(1, 1, 1, 1'b1, 3, 1'b0, 0);
    chk("R3 arrive no stall", stall, 8'h01);
    send(2, 1, 1, 1'b1, 3, 1'b0, 0);
    chk("R4 release after completing arrive", stall, 0);
  endtask

  task automatic reduce_group(input string tag, input int op, input logic [3:0] preds,
                              input logic [3:0] exp);
    for (int t = 0; t < 4; t++) send(t, 2, 2, 1'b1, 4, preds[t], op);
    chk({tag, " red_valid"}, s_rv, 1);
    chk({tag, " red_value"}, s_val, exp);
    chk({tag, " red_mask"}, s_mask, 8'h0F);
    chk({tag, " red_bar"}, s_bar, 2);
    clear_fence(8'h0F);
  endtask

  task automatic t_reduce;
    reduce_group("R6 AND", 0, 4'b1011, 4'd0);
    reduce_group("R6 OR zero", 1, 4'b0000, 4'd0);
    reduce_group("R6 POPC", 2, 4'b1101, 4'd3);
    reduce_group("R9 reuse AND true", 0, 4'b1111, 4'd1);
    chk("R6 stall after fences", stall, 0);
  endtask

  task automatic t_badidx;
    send(5, 5, 0, 1'b0, 0, 1'b0, 0);
    chk("R1 err_req", s_er, 1);
    chk("R1 no stall", stall[5], 0);
  endtask

  task automatic t_arrive_nocount;
    send(0, 3, 0, 1'b1, 2, 1'b0, 0);
    clear_fence(8'h01);
    send(1, 3, 1, 1'b0, 0, 1'b0, 0);
    chk("R3 arrive without count errs", s_er, 1);
    chk("R3 not counted", stall[0], 1);
    send(1, 3, 0, 1'b1, 2, 1'b0, 0);
    chk("R4 completes with second", stall, 8'h02);
    clear_fence(8'h02);
  endtask

  task automatic t_mismatch;
    send(0, 1, 0, 1'b1, 2, 1'b0, 0);
    send(1, 1, 0, 1'b1, 3, 1'b0, 0);
    chk("R7 err_mismatch", s_em, 1);
    clear_fence(8'h03);
    chk("R7 latched count used", stall, 0);
  endtask

  task automatic t_ready;
    send(4, 0, 0, 1'b1, 2, 1'b0, 0);
    @(negedge clk);
    req_tid = 3'd4;
    #1 chk("R10 ready low for stalled", req_ready, 0);
    req_tid = 3'd5;
    #1 chk("R10 ready high for free", req_ready, 1);
    send(5, 0, 1, 1'b1, 2, 1'b0, 0);
    clear_fence(8'h10);
    chk("R10 released", stall, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_all();
        t_arrive();
        t_reduce();
        t_badidx();
        t_arrive_nocount();
        t_mismatch();
        t_ready();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule